// File: doc/BRIEF.md
# Seven-Level Carrier PWM Gate Generator

This block produces the twelve gate signals of a single-phase seven-level inverter whose output steps in units of one third of full scale, from -3 to +3 units. Each clock it takes a signed modulating sample and compares it with fixed thresholds at 0 and at plus and minus one and two thirds of full scale. That comparison picks one of six bands, three per half wave. Within the selected band it compares the sample with a level-shifted triangular carrier. That second comparison decides between the two output levels at the edges of the band.

Every output level has its own fixed set of switches that are on. All other switches are off. The chosen set is registered once per clock and driven on the gate outputs, and the level is reported as a signed number alongside it.

The sample comes from one of two sources. The first is an internal sine generator, built from a computed quarter-wave table and scaled by a programmable modulation index. The second is an external input. The carrier rate is set by a phase-increment input, which covers the usual 200 Hz to 2 kHz switching range at practical clock rates.

Top module: `sevlvl_pwm_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, after that edge `gate` carries the level-0 switch set and `level` reads 0.
- R2: `gate[n-1]` drives switch Sn. The on-sets are: 0 → {S2,S3,S5,S8,S10,S12}; +1 → {S2,S3,S5,S6,S9,S11}; +2 → {S2,S4,S6,S9,S11}; +3 → {S3,S4,S6,S7,S10,S11}; -1 → {S1,S8,S10,S12}; -2 → {S2,S6,S7,S8,S9,S12}; -3 → {S1,S7,S8,S9,S12}. Every switch outside the set is 0, and no other pattern is ever driven.
- R3: `level` is a 3-bit two's-complement value equal to the level whose set is on `gate` in the same cycle.
- R4: With T = 10922 (one third of 32767), a sample s in [0,T) yields only levels 0/+1, s in [T,2T) yields +1/+2, and s ≥ 2T yields +2/+3. Negative samples mirror this. The exact values 0, ±T and ±2T give the constant levels 0, ±1 and ±2.
- R5: Samples of +32767 give +3 constantly and -32767 gives -3. An external -32768 is treated as -32767.
- R6: Inside a band, the share of time spent at the level of larger magnitude equals the sample's fractional position in the band, measured over whole carrier periods.
- R7: The carrier period is 2^`CAR_ACC_W` / `car_step` clocks. A sample held inside a band makes two level changes per carrier period.
- R8: With `src_ext` = 0 the sample is a sine scaled by `mod_index` (unsigned Q1.15, 32768 = 1.0). An index of 0.98 reaches ±3, 0.6 reaches at most ±2 and 0.3 reaches at most ±1.
- R9: An external sample applied between clock edges appears on `gate` and `level` after the second following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ext | input | 1 | 1 selects `ext_sample`, 0 selects the internal sine |
| ext_sample | input | 16 | External signed modulating sample, ±32767 = ±full scale |
| mod_index | input | 16 | Sine modulation index, unsigned Q1.15 |
| fund_step | input | SIN_ACC_W (24) | Sine phase increment per clock |
| car_step | input | CAR_ACC_W (24) | Carrier phase increment per clock |
| gate | output | 12 | Switch gate bits, bit n-1 drives Sn |
| level | output | 3 | Signed output level, -3..+3 |

## Verification
Band selection and carrier comparison act in the same cycle. A sample that sits on a threshold, or inside a band, meets a carrier that crosses it. The bench holds the external sample on exact thresholds, at full scale and at fractional band positions, and observes whole carrier periods. Each segment is judged by the set of levels seen, the share of time at the upper level, and the count of transitions. Every registered pattern is also checked against the seven legal switch sets and the reported level.

// File: rtl/sevlvl_pkg.sv
// Shared constants, types and the level-to-switch mapping for the
// seven-level gate generator. Level -3..+3 maps to a fixed on-set of
// twelve switches; gate bit n-1 drives switch n.
package sevlvl_pkg;

    localparam int SAMPLE_W = 16;
    localparam int NUM_SW   = 12;
    localparam int NUM_LVL  = 7;
    localparam int LVL_W    = 3;
    localparam int IDX_W    = 16;

    localparam logic signed [SAMPLE_W-1:0] FULL_SCALE = 16'sd32767;
    localparam logic signed [SAMPLE_W-1:0] BAND_STEP  = 16'sd10922;

    typedef logic signed [LVL_W-1:0] level_t;
    typedef logic [NUM_SW-1:0]       gate_t;

    // Switch on-set for one output level (bit n-1 = switch n).
    function automatic gate_t level_pattern(input level_t lv);
        gate_t g;
        case (lv)
            3'sd0:  g = 12'hA96;
            3'sd1:  g = 12'h536;
            3'sd2:  g = 12'h52A;
            3'sd3:  g = 12'h66C;
            -3'sd1: g = 12'hA81;
            -3'sd2: g = 12'h9E2;
            -3'sd3: g = 12'h9C1;
            default: g = 12'hA96;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/sevlvl_sine.sv
// Internal modulating source: phase accumulator, quarter-wave table
// computed at elaboration (rational sine approximation), index scaling
// in Q1.15 with saturation, registered signed output.
// Assumes the table index width is well below the accumulator width.
module sevlvl_sine #(
    parameter int ACC_W    = 24,
    parameter int TAB_BITS = 8,
    parameter int SAMPLE_W = sevlvl_pkg::SAMPLE_W,
    parameter int IDX_W    = sevlvl_pkg::IDX_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ACC_W-1:0]           step,
    input  logic [IDX_W-1:0]           mod_index,
    output logic signed [SAMPLE_W-1:0] sample_o
);
    localparam int     TAB_N  = 1 << TAB_BITS;
    localparam int     MAG_W  = SAMPLE_W - 1;
    localparam int     PROD_W = MAG_W + IDX_W;
    localparam longint HALF   = longint'(1) << (TAB_BITS + 1);
    localparam longint CDEN   = 5 * HALF * HALF / 4;
    localparam longint AMP    = (longint'(1) << MAG_W) - 1;

    // Quarter-wave magnitude for table index a (0..TAB_N-1).
    function automatic logic [MAG_W-1:0] quarter_val(input int a);
        longint b;
        b = longint'(a) * (HALF - longint'(a));
        return MAG_W'(AMP * 4 * b / (CDEN - b));
    endfunction

    logic [MAG_W-1:0] qtab [TAB_N];
    for (genvar i = 0; i < TAB_N; i++) begin : g_tab
        assign qtab[i] = quarter_val(i);
    end

    logic [ACC_W-1:0]    phase;
    logic [1:0]          quad;
    logic [TAB_BITS-1:0] idx;
    logic [TAB_BITS-1:0] addr;
    logic [MAG_W-1:0]    mag;
    logic [PROD_W-1:0]   prod;
    logic [PROD_W-1:0]   scaled;
    logic [MAG_W-1:0]    lim;

    assign quad   = phase[ACC_W-1 -: 2];
    assign idx    = phase[ACC_W-3 -: TAB_BITS];
    assign addr   = quad[0] ? ~idx : idx;
    assign mag    = qtab[addr];
    assign prod   = PROD_W'(mag) * PROD_W'(mod_index);
    assign scaled = prod >> (IDX_W - 1);
    assign lim    = (scaled > PROD_W'(AMP)) ? {MAG_W{1'b1}} : scaled[MAG_W-1:0];

    // Advance the sine phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + step;
    end

    // Register the signed, scaled sample.
    always_ff @(posedge clk) begin
        if (!rst_n)       sample_o <= '0;
        else if (quad[1]) sample_o <= -$signed({1'b0, lim});
        else              sample_o <= $signed({1'b0, lim});
    end

    // R8: the scaled sine never leaves the symmetric range.
    a_r8_sine_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o != {1'b1, {(SAMPLE_W-1){1'b0}}});

endmodule

// File: rtl/sevlvl_carrier.sv
// Shared unit triangle carrier: phase accumulator folded into a
// symmetric ramp of OUT_W bits. The period is 2^ACC_W / step clocks.
// Assumes ACC_W >= OUT_W + 1.
module sevlvl_carrier #(
    parameter int ACC_W = 24,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step,
    output logic [OUT_W-1:0] wave_o
);
    logic [ACC_W-1:0] phase;
    logic [OUT_W-1:0] ramp;

    assign ramp = phase[ACC_W-2 -: OUT_W];

    // Advance the carrier phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + step;
    end

    // Fold the ramp into a triangle on the phase MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)              wave_o <= '0;
        else if (phase[ACC_W-1]) wave_o <= ~ramp;
        else                     wave_o <= ramp;
    end

endmodule

// File: rtl/sevlvl_band.sv
// Band detection and per-band carrier comparison. Threshold compares
// at 0, T, 2T (and their negatives) combine by XOR into six exclusive
// band flags. Each band compares the sample against its own
// level-shifted carrier; the flag gated with the compare result or its
// complement selects the upper or lower level of the band. The output
// is a one-hot level vector, bit j = level j-3.
// Assumes the sample never equals the most negative code.
module sevlvl_band #(
    parameter int SAMPLE_W = sevlvl_pkg::SAMPLE_W,
    parameter int CAR_W    = 16,
    parameter int NUM_LVL  = sevlvl_pkg::NUM_LVL
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [CAR_W-1:0]           wave,
    output logic [NUM_LVL-1:0]         lvl_hot
);
    localparam int EXT_W   = SAMPLE_W + 2;
    localparam int NBAND   = (NUM_LVL - 1) / 2;
    localparam int OPROD_W = CAR_W + SAMPLE_W;
    localparam int MID     = NBAND;
    localparam logic signed [EXT_W-1:0] STEP_E = EXT_W'(sevlvl_pkg::BAND_STEP);

    logic [OPROD_W-1:0]     ofs_prod;
    logic [SAMPLE_W-1:0]    ofs;
    logic signed [EXT_W-1:0] s_ext;
    logic signed [EXT_W-1:0] ofs_ext;
    logic [NBAND-1:0] ge, lt, pband, nband, qp, qn;
    logic [NBAND-1:0] up_p, dn_p, up_n, dn_n;

    assign ofs_prod = OPROD_W'(wave) * OPROD_W'(sevlvl_pkg::BAND_STEP);
    assign ofs      = SAMPLE_W'(ofs_prod >> CAR_W);
    assign s_ext    = EXT_W'(sample);
    assign ofs_ext  = $signed({2'b00, ofs});

    for (genvar k = 0; k < NBAND; k++) begin : g_band
        localparam logic signed [EXT_W-1:0] THR = EXT_W'(k) * STEP_E;
        assign ge[k] = s_ext >= THR;
        assign lt[k] = s_ext < -THR;
        assign qp[k] = s_ext > (THR + ofs_ext);
        assign qn[k] = s_ext < -(THR + ofs_ext);
        if (k == NBAND - 1) begin : g_top
            assign pband[k] = ge[k];
            assign nband[k] = lt[k];
        end else begin : g_mid
            assign pband[k] = ge[k] ^ ge[k+1];
            assign nband[k] = lt[k] ^ lt[k+1];
        end
        assign up_p[k] = pband[k] & qp[k];
        assign dn_p[k] = pband[k] & ~qp[k];
        assign up_n[k] = nband[k] & qn[k];
        assign dn_n[k] = nband[k] & ~qn[k];
    end

    // OR the per-band selections into the one-hot level vector.
    always_comb begin
        lvl_hot = '0;
        for (int k = 0; k < NBAND; k++) begin
            lvl_hot[MID+1+k] = lvl_hot[MID+1+k] | up_p[k];
            lvl_hot[MID+k]   = lvl_hot[MID+k]   | dn_p[k];
            lvl_hot[MID-1-k] = lvl_hot[MID-1-k] | up_n[k];
            lvl_hot[MID-k]   = lvl_hot[MID-k]   | dn_n[k];
        end
    end

    // R4: exactly one band is active at a time.
    a_r4_one_band: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({pband, nband}));

    // R4: the band logic selects exactly one level.
    a_r4_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lvl_hot));

endmodule

// File: rtl/sevlvl_gate_map.sv
// Maps the one-hot level vector to its twelve-switch on-set and the
// signed level code, and registers both so that every driven pattern
// is complete and glitch-free. Assumes the input vector is one-hot.
module sevlvl_gate_map #(
    parameter int NUM_LVL = sevlvl_pkg::NUM_LVL
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LVL-1:0]   lvl_hot,
    output sevlvl_pkg::gate_t    gate_o,
    output sevlvl_pkg::level_t   level_o
);
    import sevlvl_pkg::*;
    localparam int MID = (NUM_LVL - 1) / 2;

    gate_t  pat [NUM_LVL];
    level_t code [NUM_LVL];
    gate_t  gate_nxt;
    level_t level_nxt;

    for (genvar j = 0; j < NUM_LVL; j++) begin : g_lut
        assign code[j] = level_t'(j - MID);
        assign pat[j]  = level_pattern(level_t'(j - MID));
    end

    // OR together the pattern and code of the selected level.
    always_comb begin
        gate_nxt  = '0;
        level_nxt = '0;
        for (int j = 0; j < NUM_LVL; j++) begin
            if (lvl_hot[j]) begin
                gate_nxt  = gate_nxt | pat[j];
                level_nxt = level_nxt | code[j];
            end
        end
    end

    // Register the outputs; reset parks on the level-0 set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_o  <= level_pattern(3'sd0);
            level_o <= 3'sd0;
        end else begin
            gate_o  <= gate_nxt;
            level_o <= level_nxt;
        end
    end

    // R2: only one of the seven legal switch sets is ever driven.
    a_r2_legal_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o == 12'hA96) || (gate_o == 12'h536) || (gate_o == 12'h52A) ||
        (gate_o == 12'h66C) || (gate_o == 12'hA81) || (gate_o == 12'h9E2) ||
        (gate_o == 12'h9C1));

    // R3: the level code and the switch set always agree.
    a_r3_level_matches_gate: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o == level_pattern(level_o));

endmodule

// File: rtl/sevlvl_pwm_gen.sv
// Seven-level carrier PWM gate generator top. Selects the modulating
// sample (internal sine or saturated external input), registers it,
// finds band and level against a shared level-shifted carrier, and
// drives the registered switch set. Two clocks from an external
// sample change to the gates.
module sevlvl_pwm_gen #(
    parameter int SIN_ACC_W    = 24,
    parameter int SIN_TAB_BITS = 8,
    parameter int CAR_ACC_W    = 24,
    parameter int CAR_W        = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    src_ext,
    input  logic signed [15:0]      ext_sample,
    input  logic [15:0]             mod_index,
    input  logic [SIN_ACC_W-1:0]    fund_step,
    input  logic [CAR_ACC_W-1:0]    car_step,
    output logic [11:0]             gate,
    output logic signed [2:0]       level
);
    import sevlvl_pkg::*;

    logic signed [SAMPLE_W-1:0] sine_smp;
    logic signed [SAMPLE_W-1:0] sample_q;
    logic signed [SAMPLE_W-1:0] ext_sat;
    logic [CAR_W-1:0]           wave;
    logic [NUM_LVL-1:0]         lvl_hot;

    sevlvl_sine #(
        .ACC_W(SIN_ACC_W), .TAB_BITS(SIN_TAB_BITS),
        .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)
    ) i_sine (
        .clk(clk), .rst_n(rst_n), .step(fund_step),
        .mod_index(mod_index), .sample_o(sine_smp)
    );

    sevlvl_carrier #(.ACC_W(CAR_ACC_W), .OUT_W(CAR_W)) i_carrier (
        .clk(clk), .rst_n(rst_n), .step(car_step), .wave_o(wave)
    );

    assign ext_sat = (ext_sample == {1'b1, {(SAMPLE_W-1){1'b0}}}) ? -FULL_SCALE : ext_sample;

    // Register the selected modulating sample.
    always_ff @(posedge clk) begin
        if (!rst_n)       sample_q <= '0;
        else if (src_ext) sample_q <= ext_sat;
        else              sample_q <= sine_smp;
    end

    sevlvl_band #(.SAMPLE_W(SAMPLE_W), .CAR_W(CAR_W), .NUM_LVL(NUM_LVL)) i_band (
        .clk(clk), .rst_n(rst_n), .sample(sample_q), .wave(wave), .lvl_hot(lvl_hot)
    );

    sevlvl_gate_map #(.NUM_LVL(NUM_LVL)) i_gate_map (
        .clk(clk), .rst_n(rst_n), .lvl_hot(lvl_hot), .gate_o(gate), .level_o(level)
    );

    // R1: reset parks the outputs on the level-0 set.
    a_r1_reset_zero_level: assert property (@(posedge clk)
        !rst_n |=> (gate == 12'hA96) && (level == 3'sd0));

    // R5: positive full scale always yields +3.
    a_r5_full_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q == FULL_SCALE) |=> (level == 3'sd3));

    // R5: negative full scale always yields -3.
    a_r5_full_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q == -FULL_SCALE) |=> (level == -3'sd3));

    // R4: a zero sample always yields level 0.
    a_r4_zero_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q == '0) |=> (level == 3'sd0));

endmodule

// File: tb/test_sevlvl_pwm_gen.sv
// Scoreboard bench: the driver applies a stimulus segment and pushes
// its expectations; the monitor pops them and judges the outputs.
module test_sevlvl_pwm_gen;

    localparam int SETTLE = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               src_ext = 1'b1;
    logic signed [15:0] ext_sample = '0;
    logic [15:0]        mod_index = '0;
    logic [23:0]        fund_step = 24'd2048;
    logic [23:0]        car_step = 24'd16384;
    logic [11:0]        gate;
    logic signed [2:0]  level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit              ext;
        logic signed [15:0] smp;
        logic [15:0]     midx;
        logic [23:0]     cstep;
        int              lo, hi;
        bit              reach;
        int              dlev, dmin, dmax;
        int              tmin, tmax;
        int              n;
        string           req;
    } seg_t;

    seg_t sb_q[$];

    always #5 clk = ~clk;

    sevlvl_pwm_gen i_sevlvl_pwm_gen (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .ext_sample(ext_sample),
        .mod_index(mod_index), .fund_step(fund_step), .car_step(car_step),
        .gate(gate), .level(level)
    );

    // Switch list to gate bits (0 = unused slot).
    function automatic logic [11:0] sw_set(input int a, b, c, d, e, f);
        logic [11:0] g = '0;
        int l [6] = '{a, b, c, d, e, f};
        foreach (l[i]) if (l[i] > 0) g[l[i]-1] = 1'b1;
        return g;
    endfunction

    function automatic logic [11:0] exp_pat(input int lv);
        case (lv)
            0:  return sw_set(2, 3, 5, 8, 10, 12);
            1:  return sw_set(2, 3, 5, 6, 9, 11);
            2:  return sw_set(2, 4, 6, 9, 11, 0);
            3:  return sw_set(3, 4, 6, 7, 10, 11);
            -1: return sw_set(1, 8, 10, 12, 0, 0);
            -2: return sw_set(2, 6, 7, 8, 9, 12);
            -3: return sw_set(1, 7, 8, 9, 12, 0);
            default: return 12'h000;
        endcase
    endfunction

    function automatic int decode(input logic [11:0] g);
        for (int lv = -3; lv <= 3; lv++) if (exp_pat(lv) == g) return lv;
        return 99;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver side: apply a segment on a falling edge and queue its expectations.
    task automatic run_seg(input bit ext, input int smp, input int midx, input int cstep,
                           input int lo, input int hi, input bit reach,
                           input int dlev, input int dmin, input int dmax,
                           input int tmin, input int tmax, input int n, input string req);
        seg_t it;
        it.ext = ext; it.smp = 16'(smp); it.midx = 16'(midx); it.cstep = 24'(cstep);
        it.lo = lo; it.hi = hi; it.reach = reach;
        it.dlev = dlev; it.dmin = dmin; it.dmax = dmax;
        it.tmin = tmin; it.tmax = tmax; it.n = n; it.req = req;
        src_ext = ext; ext_sample = it.smp; mod_index = it.midx; car_step = it.cstep;
        sb_q.push_back(it);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop each segment and judge the observed outputs.
    initial begin : monitor
        forever begin
            seg_t it;
            int mn, mx, bad, hits, trans, cnt, prev, lv;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            repeat (SETTLE) @(negedge clk);
            mn = 99; mx = -99; bad = 0; hits = 0; trans = 0; cnt = 0; prev = 99;
            for (int i = 0; i < it.n - SETTLE; i++) begin
                @(negedge clk);
                lv = int'(level);
                if (decode(gate) != lv) bad++;
                if (lv < mn) mn = lv;
                if (lv > mx) mx = lv;
                if (lv == it.dlev) hits++;
                if (prev != 99 && lv != prev) trans++;
                prev = lv;
                cnt++;
            end
            // R2/R3: every pattern is a legal set matching the level port.
            check(bad == 0, "R2", "cycles with gate not matching level set", bad, 0);
            check(mn >= it.lo, it.req, "lowest level", mn, it.lo);
            check(mx <= it.hi, it.req, "highest level", mx, it.hi);
            if (it.reach) begin
                check(mn == it.lo, it.req, "lowest level reached", mn, it.lo);
                check(mx == it.hi, it.req, "highest level reached", mx, it.hi);
            end
            if (it.dmin >= 0) begin
                check((hits * 100 / cnt) >= it.dmin && (hits * 100 / cnt) <= it.dmax,
                      it.req, "percent at upper level", hits * 100 / cnt, it.dmin);
            end
            if (it.tmin >= 0) begin
                check(trans >= it.tmin && trans <= it.tmax, it.req,
                      "level transitions", trans, it.tmin);
            end
        end
    end

    // Driver: reset, latency and the stimulus segments.
    initial begin : driver
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(gate == exp_pat(0), "R1", "gate in reset", int'(gate), int'(exp_pat(0)));
        check(level == 3'sd0, "R1", "level in reset", int'(level), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R9: two-edge latency from the external sample to the gates.
        ext_sample = 16'sd32767;
        @(negedge clk);
        check(int'(level) == 0, "R9", "level one edge after change", int'(level), 0);
        @(negedge clk);
        check(int'(level) == 3, "R9", "level two edges after change", int'(level), 3);
        check(gate == exp_pat(3), "R2", "gate for +3", int'(gate), int'(exp_pat(3)));
        // R1: reset while running returns to the level-0 set.
        rst_n = 1'b0;
        @(negedge clk);
        check(gate == exp_pat(0), "R1", "gate after mid-run reset", int'(gate), int'(exp_pat(0)));
        check(level == 3'sd0, "R1", "level after mid-run reset", int'(level), 0);
        rst_n = 1'b1;
        ext_sample = '0;
        repeat (4) @(negedge clk);

        // R4/R5: exact thresholds and full scale give constant levels.
        run_seg(1, 0,      0, 16384, 0, 0, 1, 0, -1, 0, -1, 0, 1032, "R4");
        run_seg(1, 32767,  0, 16384, 3, 3, 1, 3, -1, 0, -1, 0, 1032, "R5");
        run_seg(1, -32768, 0, 16384, -3, -3, 1, -3, -1, 0, -1, 0, 1032, "R5");
        run_seg(1, -32767, 0, 16384, -3, -3, 1, -3, -1, 0, -1, 0, 1032, "R5");
        run_seg(1, 10922,  0, 16384, 1, 1, 1, 1, -1, 0, -1, 0, 1032, "R4");
        run_seg(1, -10922, 0, 16384, -1, -1, 1, -1, -1, 0, -1, 0, 1032, "R4");
        run_seg(1, 21844,  0, 16384, 2, 2, 1, 2, -1, 0, -1, 0, 1032, "R4");
        run_seg(1, -21844, 0, 16384, -2, -2, 1, -2, -1, 0, -1, 0, 1032, "R4");

        // R6: duty within a band follows the sample's position.
        run_seg(1, 16383,  0, 16384, 1, 2, 1, 2, 45, 55, -1, 0, 4104, "R6");
        run_seg(1, -16383, 0, 16384, -2, -1, 1, -2, 45, 55, -1, 0, 4104, "R6");
        run_seg(1, 5461,   0, 16384, 0, 1, 1, 1, 45, 55, -1, 0, 4104, "R6");
        run_seg(1, 13652,  0, 16384, 1, 2, 1, 2, 20, 30, -1, 0, 4104, "R6");
        run_seg(1, 27305,  0, 16384, 2, 3, 1, 3, 45, 55, -1, 0, 4104, "R6");

        // R7: carrier rate sets the transition count.
        run_seg(1, 16383,  0, 16384, 1, 2, 0, 2, -1, 0, 7, 9, 4104, "R7");
        run_seg(1, 16383,  0, 32768, 1, 2, 0, 2, -1, 0, 15, 17, 4104, "R7");

        // R8: internal sine, level count follows the modulation index.
        run_seg(0, 0, 32113, 65536, -3, 3, 1, 9, -1, 0, -1, 0, 16392, "R8");
        run_seg(0, 0, 19661, 65536, -2, 2, 1, 9, -1, 0, -1, 0, 16392, "R8");
        run_seg(0, 0, 9830,  65536, -1, 1, 1, 9, -1, 0, -1, 0, 16392, "R8");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule